// File: doc/BRIEF.md
# Cascaded Interrupt Cause Controller

The block collects 96 level-sensitive interrupt sources into three 32-bit cause words and answers interrupt-number queries from two processors. A low main word and a high main word follow their source lines directly. A third word records general-purpose pin events and holds them until software clears them. Four positions of the high word are not driven by sources. Each of them is the summary of one group of eight enabled pin bits, so pin interrupts sit behind the high word.

Processor 0 sees every enabled source. It pulses a request and, on the next clock edge, receives one interrupt number. The low word is searched first, then the high word, and then, if a summary bit won, the pin word. A reported pin bit is cleared in the same edge. Processor 1 has its own low mask and only ever sees the doorbell bit. A small register port reads the three cause words and reads or writes the four masks. The pin cause word is cleared by writing zeros into it.

Top module: `intr_cause_ctrl`

## Requirements
- R1: After reset every mask reads zero, except that the processor-0 high mask reads 0x0F000000 (bits 24 to 27 set). The pin cause word reads zero and both valid outputs are low.
- R2: The low cause word (address 0) equals lo_src_i in the same cycle, and the high cause word (address 1) equals hi_src_i in the same cycle. The exception is high bit 24+k, for k from 0 to 3, which reads as the OR of (pin cause AND pin mask) over bits 8k to 8k+7. Source values on hi_src_i bits 24 to 27 have no effect.
- R3: A one on pin_set_i sets that pin cause bit at the clock edge, and the bit stays set. A write to address 2 ANDs the data into the pin cause word: a zero clears the bit and a one leaves it unchanged. A set in the same cycle wins over any clear.
- R4: Only low bits in 0x3DFFFFFE and high bits in 0x1F0003F7 take part in processor-0 resolution.
- R5: Processor-0 resolution reports the lowest enabled pending low bit n as number n. Only when there is none does it report the lowest enabled pending eligible high bit m as 32+m.
- R6: When the winning high bit lies in positions 24 to 27, the report is 64+p, where p is the lowest pending pin bit that is also set in the pin mask.
- R7: When pin p is reported, pin cause bit p is cleared at the same edge where the result appears, unless pin_set_i sets it again.
- R8: When no eligible enabled bit is pending, processor 0 receives code 127.
- R9: A query pulse on cpu0_req_i or cpu1_req_i in a cycle raises the matching valid output for exactly the next cycle, with the number beside it. Without a request the valid output stays low.
- R10: Processor 1 receives 28 when low cause bit 28 and its own mask bit 28 are both set, and code 126 otherwise. All other bits of its mask and of the low word have no effect on it.
- R11: Register addresses are: 0 low cause, 1 high cause, 2 pin cause, 3 processor-0 low mask, 4 processor-0 high mask, 5 pin mask, 6 processor-1 low mask. Address 7 reads zero. Writes to addresses 0, 1 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lo_src_i | input | 32 | Level sources of the low main word |
| hi_src_i | input | 32 | Level sources of the high main word (bits 24 to 27 unused) |
| pin_set_i | input | 32 | Pin events that set pin cause bits |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on the address |
| cpu0_req_i | input | 1 | Processor-0 query strobe |
| cpu0_valid_o | output | 1 | Processor-0 result valid |
| cpu0_num_o | output | 7 | Processor-0 interrupt number or code 127 |
| cpu1_req_i | input | 1 | Processor-1 query strobe |
| cpu1_valid_o | output | 1 | Processor-1 result valid |
| cpu1_num_o | output | 7 | Processor-1 result: 28 or code 126 |

## Verification
A corrupted mask or pin cause bit shows up on the read port in the cycle after the faulty edge. It also shows up on the next query, as a wrong winner or a spurious code. A pin bit that fails to clear after it is reported makes the following query return the same pin number again, one cycle after that query. A wrong summary is visible at once on high-word bits 24 to 27. The model compares reads and both result channels every cycle, so any such divergence is caught within one cycle of the point where it becomes observable.

// File: rtl/intr_cause_pkg.sv
package intr_cause_pkg;
  localparam int WORD_W    = 32;
  localparam int IDX_W     = $clog2(WORD_W);
  localparam int NUM_W     = 7;
  localparam int SUM_LSB   = 24;
  localparam int SUM_N     = 4;
  localparam int GRP_W     = WORD_W / SUM_N;
  localparam int DOORBELL  = 28;
  localparam logic [WORD_W-1:0] LO_ELIG  = 32'h3DFF_FFFE;
  localparam logic [WORD_W-1:0] HI_ELIG  = 32'h1F00_03F7;
  localparam logic [WORD_W-1:0] SUM_MASK = WORD_W'(((1 << SUM_N) - 1) << SUM_LSB);
  localparam logic [NUM_W-1:0]  CODE_SPUR = 7'd127;
  localparam logic [NUM_W-1:0]  CODE_NONE = 7'd126;

  typedef enum logic [2:0] {
    A_LO_CAUSE = 3'd0,
    A_HI_CAUSE = 3'd1,
    A_PIN_CAUSE = 3'd2,
    A_M0_LO    = 3'd3,
    A_M0_HI    = 3'd4,
    A_PIN_MASK = 3'd5,
    A_M1_LO    = 3'd6,
    A_RSVD     = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/icc_lowest.sv
module icc_lowest #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/icc_pin_bank.sv
module icc_pin_bank #(
  parameter int PINS   = 32,
  parameter int GROUPS = 4,
  localparam int GW    = PINS / GROUPS,
  localparam int PIW   = $clog2(PINS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PINS-1:0]   set_i,
  input  logic              wr_en_i,
  input  logic [PINS-1:0]   wr_data_i,
  input  logic              clr_en_i,
  input  logic [PIW-1:0]    clr_idx_i,
  input  logic [PINS-1:0]   mask_i,
  output logic [PINS-1:0]   cause_o,
  output logic [GROUPS-1:0] summary_o
);
  logic [PINS-1:0] cause_q, cause_d;

  always_comb begin
    cause_d = cause_q;
    if (wr_en_i) cause_d = cause_d & wr_data_i;
    if (clr_en_i) cause_d[clr_idx_i] = 1'b0;
    cause_d = cause_d | set_i;  // new events win over clears
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= cause_d;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_sum
    assign summary_o[g] = |(cause_q[g*GW +: GW] & mask_i[g*GW +: GW]);
  end

  assign cause_o = cause_q;

  // R7: a reported pin is gone one edge later unless re-set
  assert_pin_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !set_i[clr_idx_i]) |=> !cause_q[$past(clr_idx_i)]);

  // R3: with no write and no clear, pending pins stay pending
  assert_pin_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !clr_en_i) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

// File: rtl/intr_cause_ctrl.sv
module intr_cause_ctrl
  import intr_cause_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] lo_src_i,
  input  logic [WORD_W-1:0] hi_src_i,
  input  logic [WORD_W-1:0] pin_set_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic              cpu0_req_i,
  output logic              cpu0_valid_o,
  output logic [NUM_W-1:0]  cpu0_num_o,
  input  logic              cpu1_req_i,
  output logic              cpu1_valid_o,
  output logic [NUM_W-1:0]  cpu1_num_o
);
  logic [WORD_W-1:0] m0_lo_q, m0_hi_q, pin_mask_q, m1_lo_q;
  logic [WORD_W-1:0] pin_cause, hi_word;
  logic [SUM_N-1:0]  pin_sum;
  reg_addr_e         addr;
  logic              wr_pin, clr_en;

  logic              lo_any, hi_any, pin_any, hi_is_sum;
  logic [IDX_W-1:0]  lo_idx, hi_idx, pin_idx;
  logic [NUM_W-1:0]  num0_d, num1_d;

  assign addr   = reg_addr_e'(reg_addr_i);
  assign wr_pin = reg_we_i && (addr == A_PIN_CAUSE);

  icc_pin_bank #(.PINS(WORD_W), .GROUPS(SUM_N)) u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (pin_set_i),
    .wr_en_i   (wr_pin),
    .wr_data_i (reg_wdata_i),
    .clr_en_i  (clr_en),
    .clr_idx_i (pin_idx),
    .mask_i    (pin_mask_q),
    .cause_o   (pin_cause),
    .summary_o (pin_sum)
  );

  always_comb begin
    hi_word = hi_src_i;
    hi_word[SUM_LSB +: SUM_N] = pin_sum;
  end

  icc_lowest #(.W(WORD_W)) u_lo  (.vec_i(lo_src_i & LO_ELIG & m0_lo_q), .any_o(lo_any),  .idx_o(lo_idx));
  icc_lowest #(.W(WORD_W)) u_hi  (.vec_i(hi_word & HI_ELIG & m0_hi_q),  .any_o(hi_any),  .idx_o(hi_idx));
  icc_lowest #(.W(WORD_W)) u_pin (.vec_i(pin_cause & pin_mask_q),       .any_o(pin_any), .idx_o(pin_idx));

  assign hi_is_sum = (32'(hi_idx) >= SUM_LSB) && (32'(hi_idx) < SUM_LSB + SUM_N);

  always_comb begin
    clr_en = 1'b0;
    if (lo_any)                  num0_d = NUM_W'(lo_idx);
    else if (hi_any && !hi_is_sum) num0_d = NUM_W'(WORD_W) + NUM_W'(hi_idx);
    else if (hi_any && pin_any) begin
      num0_d = NUM_W'(2 * WORD_W) + NUM_W'(pin_idx);
      clr_en = cpu0_req_i;
    end
    else                         num0_d = CODE_SPUR;
  end

  assign num1_d = (lo_src_i[DOORBELL] && m1_lo_q[DOORBELL]) ? NUM_W'(DOORBELL) : CODE_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m0_lo_q      <= '0;
      m0_hi_q      <= SUM_MASK;
      pin_mask_q   <= '0;
      m1_lo_q      <= '0;
      cpu0_valid_o <= 1'b0;
      cpu0_num_o   <= '0;
      cpu1_valid_o <= 1'b0;
      cpu1_num_o   <= '0;
    end else begin
      if (reg_we_i) begin
        case (addr)
          A_M0_LO:    m0_lo_q    <= reg_wdata_i;
          A_M0_HI:    m0_hi_q    <= reg_wdata_i;
          A_PIN_MASK: pin_mask_q <= reg_wdata_i;
          A_M1_LO:    m1_lo_q    <= reg_wdata_i;
          default: ;
        endcase
      end
      cpu0_valid_o <= cpu0_req_i;
      cpu1_valid_o <= cpu1_req_i;
      if (cpu0_req_i) cpu0_num_o <= num0_d;
      if (cpu1_req_i) cpu1_num_o <= num1_d;
    end
  end

  always_comb begin
    case (addr)
      A_LO_CAUSE:  reg_rdata_o = lo_src_i;
      A_HI_CAUSE:  reg_rdata_o = hi_word;
      A_PIN_CAUSE: reg_rdata_o = pin_cause;
      A_M0_LO:     reg_rdata_o = m0_lo_q;
      A_M0_HI:     reg_rdata_o = m0_hi_q;
      A_PIN_MASK:  reg_rdata_o = pin_mask_q;
      A_M1_LO:     reg_rdata_o = m1_lo_q;
      default:     reg_rdata_o = '0;
    endcase
  end

  // R9: a result appears only for a request one edge earlier
  assert_valid_after_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu0_valid_o |-> $past(cpu0_req_i));

  // R8: processor-0 results are a real number or the spurious code
  assert_num_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu0_valid_o |-> (cpu0_num_o < NUM_W'(3 * WORD_W) || cpu0_num_o == CODE_SPUR));

  // R10: processor 1 only ever sees the doorbell or the no-interrupt code
  assert_cpu1_doorbell_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu1_valid_o |-> (cpu1_num_o == NUM_W'(DOORBELL) || cpu1_num_o == CODE_NONE));

  // R6: a pin number is only reported when a pin bit was pending and enabled
  assert_pin_report_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu0_valid_o && cpu0_num_o >= NUM_W'(2 * WORD_W) && cpu0_num_o < NUM_W'(3 * WORD_W))
      |-> $past(pin_any));
endmodule

// File: tb/intr_cause_ctrl_test.sv
module intr_cause_ctrl_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lo_src = '0, hi_src = '0, pin_set = '0, wdata = '0;
  logic        we = 1'b0, q0_req = 1'b0, q1_req = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] rdata;
  logic        v0, v1;
  logic [6:0]  n0, n1;

  int checks = 0, errors = 0;
  string tag = "R1 reset";

  // reference model state
  logic [31:0] m_pin = '0, m_mlo = '0, m_mhi = 32'h0F00_0000, m_mpin = '0, m_m1 = '0;
  logic        e_v0 = 1'b0, e_v1 = 1'b0;
  int          e_n0 = 0, e_n1 = 0;

  intr_cause_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .lo_src_i(lo_src), .hi_src_i(hi_src), .pin_set_i(pin_set),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu0_req_i(q0_req), .cpu0_valid_o(v0), .cpu0_num_o(n0),
    .cpu1_req_i(q1_req), .cpu1_valid_o(v1), .cpu1_num_o(n1)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int lowest(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] hi_view();
    logic [31:0] r = hi_src;
    for (int k = 0; k < 4; k++) r[24+k] = |(m_pin[8*k +: 8] & m_mpin[8*k +: 8]);
    return r;
  endfunction

  function automatic logic [31:0] exp_read();
    case (addr)
      3'd0: return lo_src;
      3'd1: return hi_view();
      3'd2: return m_pin;
      3'd3: return m_mlo;
      3'd4: return m_mhi;
      3'd5: return m_mpin;
      3'd6: return m_m1;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pin = '0; m_mlo = '0; m_mhi = 32'h0F00_0000; m_mpin = '0; m_m1 = '0;
      e_v0 = 1'b0; e_v1 = 1'b0;
    end else begin
      int a;
      int c;
      logic [31:0] p;
      c = -1;
      if (q0_req) begin
        a = lowest(lo_src & 32'h3DFF_FFFE & m_mlo);
        if (a >= 0) e_n0 = a;
        else begin
          a = lowest(hi_view() & 32'h1F00_03F7 & m_mhi);
          if (a < 0) e_n0 = 127;
          else if (a >= 24 && a <= 27) begin
            c = lowest(m_pin & m_mpin);
            e_n0 = (c < 0) ? 127 : 64 + c;
          end else e_n0 = 32 + a;
        end
      end
      e_v0 = q0_req;
      if (q1_req) e_n1 = (lo_src[28] && m_m1[28]) ? 28 : 126;
      e_v1 = q1_req;
      p = m_pin;
      if (we && addr == 3'd2) p = p & wdata;
      if (c >= 0) p[c] = 1'b0;
      m_pin = p | pin_set;
      if (we) begin
        case (addr)
          3'd3: m_mlo = wdata;
          3'd4: m_mhi = wdata;
          3'd5: m_mpin = wdata;
          3'd6: m_m1 = wdata;
          default: ;
        endcase
      end
    end
  end

  // compare every cycle, away from the active edge
  always begin
    @(negedge clk);
    #3;
    checks++;
    if (rdata !== exp_read()) begin
      errors++;
      $display("FAIL %s read addr %0d actual %h expected %h", tag, addr, rdata, exp_read());
    end
    checks++;
    if (v0 !== e_v0 || (e_v0 && int'(n0) != e_n0)) begin
      errors++;
      $display("FAIL %s cpu0 actual v=%b n=%0d expected v=%b n=%0d", tag, v0, n0, e_v0, e_n0);
    end
    checks++;
    if (v1 !== e_v1 || (e_v1 && int'(n1) != e_n1)) begin
      errors++;
      $display("FAIL %s cpu1 actual v=%b n=%0d expected v=%b n=%0d", tag, v1, n1, e_v1, e_n1);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1; tick(); we = 1'b0;
  endtask

  task automatic ask0();
    q0_req = 1'b1; tick(); q0_req = 1'b0; tick();
  endtask

  task automatic ask1();
    q1_req = 1'b1; tick(); q1_req = 1'b0; tick();
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tag = "R1 reset values";
    for (int a = 0; a < 8; a++) begin addr = 3'(a); tick(); end

    tag = "R11 register map";
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'h1000_0000); wr(3'd0, 32'h1234_5678); wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    for (int a = 0; a < 8; a++) begin addr = 3'(a); tick(); end

    tag = "R2 level cause and summaries";
    addr = 3'd1; hi_src = 32'h0F00_00AA; tick(2); hi_src = 32'h0; tick();
    addr = 3'd0; lo_src = 32'hDEAD_BEEF; tick(); lo_src = 32'h0; tick();

    tag = "R8 nothing pending";
    ask0();
    tag = "R4 ineligible bits";
    lo_src = 32'hC200_0001; hi_src = 32'h0F00_0008; ask0();
    lo_src = 32'h0; hi_src = 32'h0;

    tag = "R5 low before high, lowest first";
    lo_src = 32'h00F0_0010; hi_src = 32'h1; ask0();
    lo_src = 32'h0; hi_src = 32'h0000_0030; ask0();
    lo_src = 32'h0010_0010; wr(3'd3, 32'hFFFF_FFEF); ask0();
    wr(3'd3, 32'hFFFF_FFFF); lo_src = 32'h0; hi_src = 32'h0;

    tag = "R3 pin set and write-zero clear";
    addr = 3'd2; pin_set = 32'h8100_0301; tick(); pin_set = 32'h0; tick();
    wr(3'd2, 32'hFFFF_FFFE); addr = 3'd2; tick();
    pin_set = 32'h0000_0001; wr(3'd2, 32'hFFFF_FFFE); pin_set = 32'h0; addr = 3'd2; tick();
    wr(3'd2, 32'h0000_0000); addr = 3'd1; tick();

    tag = "R6 pin cascade";
    pin_set = 32'h0000_0300; tick(); pin_set = 32'h0; addr = 3'd1; ask0();
    tag = "R7 reported pin cleared";
    addr = 3'd2; ask0(); ask0();
    tag = "R6 high source beats pin summary";
    pin_set = 32'h0100_0000; hi_src = 32'h0000_0002; tick(); pin_set = 32'h0; ask0();
    hi_src = 32'h0; ask0();
    tag = "R6 masked pin gives no summary";
    pin_set = 32'h0000_0004; wr(3'd5, 32'hFFFF_FFFB); pin_set = 32'h0; addr = 3'd1; ask0();
    wr(3'd5, 32'hFFFF_FFFF); ask0();

    tag = "R9 back-to-back queries";
    lo_src = 32'h0000_0006; q0_req = 1'b1; tick(3); q0_req = 1'b0; tick(3); lo_src = 32'h0;

    tag = "R10 processor 1 doorbell";
    lo_src = 32'h1000_0000; ask1();
    lo_src = 32'hEFFF_FFFF; ask1();
    lo_src = 32'h1000_0000; wr(3'd6, 32'hEFFF_FFFF); ask1();
    wr(3'd6, 32'h1000_0000); q0_req = 1'b1; q1_req = 1'b1; tick(); q0_req = 1'b0; q1_req = 1'b0; tick();
    lo_src = 32'h0;

    tag = "R5 random mix";
    for (int i = 0; i < 600; i++) begin
      lo_src  = $urandom & $urandom;
      hi_src  = $urandom & $urandom;
      pin_set = $urandom & $urandom & $urandom;
      q0_req  = $urandom_range(0, 1) == 1;
      q1_req  = $urandom_range(0, 1) == 1;
      addr    = 3'($urandom_range(0, 7));
      we      = $urandom_range(0, 5) == 0;
      wdata   = $urandom | $urandom;
      tick();
    end
    we = 1'b0; q0_req = 1'b0; q1_req = 1'b0; pin_set = '0;
    tick(2);

    tag = "R1 reset again";
    rst_n = 1'b0; tick(2);
    for (int a = 0; a < 8; a++) begin addr = 3'(a); tick(); end
    rst_n = 1'b1; tick(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule